// File: doc/BRIEF.md
# Vectored Interrupt and Reset Sequencer

This block is the entry controller of a small 8-bit core. It owns the reset, non-maskable interrupt, maskable interrupt and software break sequences. While the core executes, the sequencer waits for the instruction-done strobe. It then stalls the core and asks the core's stack logic to push the return address. For a maskable interrupt it also asks for the status byte to be pushed. Finally it reads a 16-bit vector from a fixed table at the top of memory, low byte first, and loads the program counter with it.

The status register keeps a run bit in position 5. When an instruction completes with that bit at 0 and nothing is pending, the sequencer holds the core idle. The core stays idle until a reset, a non-maskable interrupt or an unmasked maskable interrupt arrives. A wake-up pulses a request to set the run bit again and then enters the normal interrupt sequence.

Memory is synchronous: read data belongs to the address presented in the previous cycle. The vector table holds three entries, each low byte at the lower address. The non-maskable entry is at FFFA/FFFB, reset at FFFC/FFFD, and the shared maskable-interrupt/break entry at FFFE/FFFF.

Top module: `irq_vector_seq`

## Requirements
- R1: While `rst` is high, `clear_regs` and `busy` are 1 and `mem_rd`, `pc_load`, `push_pc` and `push_psr` are 0. The core uses `clear_regs` to zero A, X and Y and to set the status byte to 20h.
- R2: In the first cycle after `rst` falls, the block reads FFFC. In the next cycle it reads FFFD. In the cycle after that it pulses `pc_load` with `pc_value` = {byte at FFFD, byte at FFFC}. Then `busy` returns to 0.
- R3: In the running state, no entry starts until `insn_done` is 1. Pending requests without `insn_done` leave `busy` at 0.
- R4: A non-maskable entry pulses `push_pc` for one cycle, never pulses `push_psr`, and reads its vector from FFFA then FFFB.
- R5: A non-maskable request is taken on its rising edge. A level held high after its entry gives no second entry.
- R6: A maskable interrupt with the I flag (`irq_mask`) at 0 pulses `push_pc`, then `push_psr` in the next cycle, then reads FFFE and FFFF.
- R7: A maskable interrupt with `irq_mask` at 1 is ignored. `busy` stays 0 when an instruction completes.
- R8: A break request with `insn_done` pulses `push_pc` together with `set_brk`. It does not push the status byte and reads FFFE then FFFF.
- R9: Priority is non-maskable over maskable over break. The maskable interrupt that lost is taken at the next instruction end.
- R10: When `insn_done` comes with `run_bit` at 0 and nothing pending, `busy` stays 1 with no memory reads, pushes or PC loads until a wake-up.
- R11: While halted, a masked interrupt does not wake the core. A non-maskable or unmasked maskable request wakes it: `set_run` pulses with `push_pc`, and the normal entry for that cause follows.
- R12: `pc_load` pulses exactly once per entry, one cycle after the high vector byte is read, and never without both reads having happened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| nmi | input | 1 | non-maskable request, edge sensitive |
| irq | input | 1 | maskable request, level |
| irq_mask | input | 1 | I flag from the status register |
| brk_req | input | 1 | break decoded, valid with `insn_done` |
| insn_done | input | 1 | current instruction completes this cycle |
| run_bit | input | 1 | status bit 5 after the completing instruction |
| rd_data | input | 8 | memory read data for the previous cycle's address |
| busy | output | 1 | core must stall |
| clear_regs | output | 1 | clear A/X/Y, status to 20h |
| mem_rd | output | 1 | vector read strobe |
| vec_addr | output | 16 | vector byte address |
| pc_load | output | 1 | load program counter |
| pc_value | output | 16 | new program counter |
| push_pc | output | 1 | push return address |
| push_psr | output | 1 | push status byte |
| set_brk | output | 1 | set the B flag |
| set_run | output | 1 | set the run bit after a wake-up |

## Verification
The assertions assume a few things about the core. `insn_done` arrives only while the block is running. `brk_req` is meaningful only alongside `insn_done`. `rd_data` follows the address one cycle later. The bench drives inputs at the falling clock edge and raises `insn_done` only when `busy` is low. A clocked memory model inside the bench supplies each vector byte one cycle after its address. `run_bit` is restored to 1 before the core resumes after a halt.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;
   typedef enum logic [2:0] {
      S_RST, S_VLO, S_VHI, S_LOAD, S_RUN, S_PUSHPC, S_PUSHPSR, S_HALT
   } seq_state_t;

   typedef enum logic [1:0] {
      C_RST, C_NMI, C_IRQ, C_BRK
   } cause_t;

   // offset of each vector from the table base
   function automatic logic [2:0] vec_offset(cause_t c);
      case (c)
         C_NMI:   return 3'd0;
         C_RST:   return 3'd2;
         default: return 3'd4;
      endcase
   endfunction
endpackage

// File: rtl/irqseq_nmi_det.sv
module irqseq_nmi_det #(
   parameter bit EDGE_MODE = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic nmi_in,
   input  logic take,
   output logic nmi_now
);
   generate
      if (EDGE_MODE) begin : g_edge
         logic nmi_q;
         logic pend_q;
         logic rise;
         assign rise    = nmi_in & ~nmi_q;
         assign nmi_now = pend_q | rise;
         always_ff @(posedge clk) begin
            if (rst) begin
               nmi_q  <= nmi_in;
               pend_q <= 1'b0;
            end else begin
               nmi_q  <= nmi_in;
               pend_q <= (pend_q | rise) & ~take;
            end
         end
         // R5: a request stays pending until it is taken
         assert_pend_kept_R5: assert property (@(posedge clk) disable iff (rst)
            (nmi_now && !take) |=> pend_q);
      end else begin : g_level
         assign nmi_now = nmi_in;
      end
   endgenerate
endmodule

// File: rtl/irqseq_arb.sv
module irqseq_arb
   import irqseq_pkg::*;
(
   input  logic   nmi_now,
   input  logic   irq_ok,
   input  logic   brk_ok,
   output logic   any,
   output cause_t win
);
   always_comb begin
      any = nmi_now | irq_ok | brk_ok;
      if (nmi_now)     win = C_NMI;
      else if (irq_ok) win = C_IRQ;
      else             win = C_BRK;
   end
endmodule

// File: rtl/irqseq_vfetch.sv
module irqseq_vfetch
   import irqseq_pkg::*;
#(
   parameter int                DATA_W   = 8,
   parameter int                ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFFA
) (
   input  logic              clk,
   input  logic              rst,
   input  cause_t            cause,
   input  logic              ph_lo,
   input  logic              ph_hi,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] vec_addr,
   output logic [ADDR_W-1:0] pc_value
);
   localparam logic [ADDR_W-1:0] VEC_LAST = VEC_BASE + ADDR_W'(5);

   logic [DATA_W-1:0] lo_q;
   logic [ADDR_W-1:0] base_addr;

   assign base_addr = VEC_BASE + ADDR_W'(vec_offset(cause));
   assign vec_addr  = ph_hi ? base_addr + ADDR_W'(1) : base_addr;
   assign pc_value  = {rd_data, lo_q};

   always_ff @(posedge clk) begin
      if (rst)        lo_q <= '0;
      else if (ph_hi) lo_q <= rd_data;
   end

   // R2: reads stay inside the vector table
   assert_vec_in_table_R2: assert property (@(posedge clk) disable iff (rst)
      (ph_lo || ph_hi) |-> (vec_addr >= VEC_BASE && vec_addr <= VEC_LAST));
   // R2: high byte read always follows a low byte read
   assert_hi_after_lo_R2: assert property (@(posedge clk) disable iff (rst)
      ph_lo |=> ph_hi);
endmodule

// File: rtl/irq_vector_seq.sv
module irq_vector_seq
   import irqseq_pkg::*;
#(
   parameter int                DATA_W    = 8,
   parameter int                ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] VEC_BASE  = 16'hFFFA,
   parameter bit                NMI_EDGE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              nmi,
   input  logic              irq,
   input  logic              irq_mask,
   input  logic              brk_req,
   input  logic              insn_done,
   input  logic              run_bit,
   input  logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              clear_regs,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] vec_addr,
   output logic              pc_load,
   output logic [ADDR_W-1:0] pc_value,
   output logic              push_pc,
   output logic              push_psr,
   output logic              set_brk,
   output logic              set_run
);
   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $fatal(1, "address must be two data bytes wide");
      end
   endgenerate

   seq_state_t state, nxt;
   cause_t     cause_q, win;
   logic       woke_q, nmi_now, irq_ok, brk_ok, any, accept, take_nmi;

   assign irq_ok   = irq & ~irq_mask;
   assign brk_ok   = brk_req & (state == S_RUN);
   assign accept   = any & (((state == S_RUN) & insn_done) | (state == S_HALT));
   assign take_nmi = accept & (win == C_NMI);

   irqseq_nmi_det #(.EDGE_MODE(NMI_EDGE)) u_nmi (
      .clk(clk), .rst(rst), .nmi_in(nmi), .take(take_nmi), .nmi_now(nmi_now));

   irqseq_arb u_arb (
      .nmi_now(nmi_now), .irq_ok(irq_ok), .brk_ok(brk_ok), .any(any), .win(win));

   irqseq_vfetch #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_vf (
      .clk(clk), .rst(rst), .cause(cause_q),
      .ph_lo(state == S_VLO), .ph_hi(state == S_VHI),
      .rd_data(rd_data), .vec_addr(vec_addr), .pc_value(pc_value));

   always_comb begin
      nxt = state;
      case (state)
         S_RST:     nxt = S_VLO;
         S_VLO:     nxt = S_VHI;
         S_VHI:     nxt = S_LOAD;
         S_LOAD:    nxt = S_RUN;
         S_RUN: begin
            if (accept)                     nxt = S_PUSHPC;
            else if (insn_done && !run_bit) nxt = S_HALT;
         end
         S_HALT:    if (accept) nxt = S_PUSHPC;
         S_PUSHPC:  nxt = (cause_q == C_IRQ) ? S_PUSHPSR : S_VLO;
         S_PUSHPSR: nxt = S_VLO;
         default:   nxt = S_RST;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= S_RST;
         cause_q <= C_RST;
         woke_q  <= 1'b0;
      end else begin
         state <= nxt;
         if (accept) begin
            cause_q <= win;
            woke_q  <= (state == S_HALT);
         end
      end
   end

   assign busy       = (state != S_RUN);
   assign clear_regs = (state == S_RST);
   assign mem_rd     = (state == S_VLO) | (state == S_VHI);
   assign pc_load    = (state == S_LOAD);
   assign push_pc    = (state == S_PUSHPC);
   assign push_psr   = (state == S_PUSHPSR);
   assign set_brk    = (state == S_PUSHPC) & (cause_q == C_BRK);
   assign set_run    = (state == S_PUSHPC) & woke_q;

   // R1: reset forces the clear state on the next cycle
   assert_reset_clears_R1: assert property (@(posedge clk)
      rst |=> (clear_regs && busy && !mem_rd));
   // R12: a PC load is preceded by two vector reads
   assert_load_after_reads_R12: assert property (@(posedge clk) disable iff (rst)
      pc_load |-> ($past(mem_rd) && $past(mem_rd, 2)));
   // R6: the status push directly follows the address push
   assert_psr_after_pc_R6: assert property (@(posedge clk) disable iff (rst)
      push_psr |-> $past(push_pc));
   // R4: at most one sequencing action per cycle
   assert_one_action_R4: assert property (@(posedge clk) disable iff (rst)
      $onehot0({push_pc, push_psr, mem_rd, pc_load}));
   // R10: a halt is left only through an entry
   assert_halt_exit_R10: assert property (@(posedge clk) disable iff (rst)
      (state == S_HALT) |=> (state == S_HALT || state == S_PUSHPC));
   // R3: the core is released only through a PC load or stays running
   assert_run_entry_R3: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> $past(pc_load));
endmodule

// File: tb/sim_irq_vector_seq.sv
`timescale 1ns/1ps
module sim_irq_vector_seq;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst, nmi, irq, irq_mask, brk_req, insn_done, run_bit;
   logic [7:0] rd_data;
   logic busy, clear_regs, mem_rd, pc_load, push_pc, push_psr, set_brk, set_run;
   logic [15:0] vec_addr, pc_value;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   irq_vector_seq u0 (.*);

   function automatic logic [7:0] vmem(logic [15:0] a);
      case (a)
         16'hFFFA: return 8'h34;
         16'hFFFB: return 8'h12;
         16'hFFFC: return 8'h00;
         16'hFFFD: return 8'h80;
         16'hFFFE: return 8'hCD;
         16'hFFFF: return 8'hAB;
         default:  return 8'hEE;
      endcase
   endfunction

   always @(posedge clk) rd_data <= vmem(vec_addr);

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // caller has just ticked into the push cycle
   task automatic expect_entry(string req, logic psr, logic brk, logic wake,
                               logic [15:0] vec, logic [15:0] pcv);
      chk(req, "push_pc", push_pc, 1);
      chk(req, "set_brk", set_brk, brk);
      chk(req, "set_run", set_run, wake);
      insn_done = 0; brk_req = 0;
      tick();
      if (psr) begin
         chk(req, "push_psr", push_psr, 1);
         tick();
      end
      chk(req, "lo read", {mem_rd, vec_addr}, {1'b1, vec});
      chk(req, "no psr push", push_psr, 0);
      tick();
      chk(req, "hi read", {mem_rd, vec_addr}, {1'b1, vec + 16'd1});
      chk(req, "no early load", pc_load, 0);
      tick();
      chk(req, "pc load", {pc_load, pc_value}, {1'b1, pcv});
      tick();
      chk(req, "released", {busy, pc_load}, 2'b00);
   endtask

   task automatic t_reset();
      rst = 1; tick(); tick();
      chk("R1", "clear/busy", {clear_regs, busy}, 2'b11);
      chk("R1", "quiet", {mem_rd, pc_load, push_pc, push_psr}, 4'b0);
      rst = 0; tick();
      chk("R2", "reset lo", {mem_rd, vec_addr}, {1'b1, 16'hFFFC});
      chk("R1", "clear off", clear_regs, 0);
      tick();
      chk("R2", "reset hi", {mem_rd, vec_addr}, {1'b1, 16'hFFFD});
      tick();
      chk("R12", "reset load", {pc_load, pc_value}, {1'b1, 16'h8000});
      tick();
      chk("R2", "running", busy, 0);
   endtask

   task automatic t_wait_done();
      irq = 1; irq_mask = 0;
      repeat (4) begin tick(); chk("R3", "wait for done", busy, 0); end
      insn_done = 1; tick();
      expect_entry("R6", 1, 0, 0, 16'hFFFE, 16'hABCD);
      irq = 0;
   endtask

   task automatic t_nmi();
      nmi = 1; insn_done = 1; tick();
      expect_entry("R4", 0, 0, 0, 16'hFFFA, 16'h1234);
      insn_done = 1; tick();
      chk("R5", "held level no reentry", {busy, push_pc}, 2'b00);
      insn_done = 0; nmi = 0; tick();
   endtask

   task automatic t_masked();
      irq = 1; irq_mask = 1; insn_done = 1; tick();
      chk("R7", "masked ignored", {busy, push_pc}, 2'b00);
      insn_done = 0; tick();
      chk("R7", "still running", busy, 0);
      irq = 0; irq_mask = 0;
   endtask

   task automatic t_brk();
      brk_req = 1; insn_done = 1; tick();
      expect_entry("R8", 0, 1, 0, 16'hFFFE, 16'hABCD);
   endtask

   task automatic t_priority();
      nmi = 1; irq = 1; brk_req = 1; insn_done = 1; tick();
      expect_entry("R9", 0, 0, 0, 16'hFFFA, 16'h1234);
      insn_done = 1; tick();
      expect_entry("R9", 1, 0, 0, 16'hFFFE, 16'hABCD);
      irq = 0; nmi = 0;
      brk_req = 1; irq = 1; insn_done = 1; tick();
      expect_entry("R9", 1, 0, 0, 16'hFFFE, 16'hABCD);
      irq = 0;
   endtask

   task automatic t_halt_irq();
      run_bit = 0; insn_done = 1; tick();
      chk("R10", "halted", busy, 1);
      insn_done = 0;
      repeat (5) begin
         tick();
         chk("R10", "idle", {busy, mem_rd, pc_load, push_pc, push_psr}, 5'b10000);
      end
      irq = 1; irq_mask = 1; tick(); tick();
      chk("R11", "masked no wake", {busy, push_pc}, 2'b10);
      irq_mask = 0; run_bit = 1; tick();
      expect_entry("R11", 1, 0, 1, 16'hFFFE, 16'hABCD);
      irq = 0;
   endtask

   task automatic t_halt_nmi();
      run_bit = 0; insn_done = 1; tick();
      insn_done = 0; tick();
      chk("R10", "halted again", {busy, mem_rd}, 2'b10);
      nmi = 1; run_bit = 1; tick();
      expect_entry("R11", 0, 0, 1, 16'hFFFA, 16'h1234);
      nmi = 0; tick();
   endtask

   initial begin
      rst = 1; nmi = 0; irq = 0; irq_mask = 0; brk_req = 0;
      insn_done = 0; run_bit = 1;
      t_reset();
      insn_done = 1; tick();
      chk("R3", "plain done", busy, 0);
      insn_done = 0;
      t_wait_done();
      t_nmi();
      t_masked();
      t_brk();
      t_priority();
      t_halt_irq();
      t_halt_nmi();
      t_reset();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule